// File: doc/BRIEF.md
# Torus Source-Routed Forwarding Stage

This block sits in one switch of a two-dimensional wrap-around mesh (torus) of K by K nodes. Every arriving header carries a destination coordinate, a payload and a route written as a short list of run-length segments. Each segment names one of four directions and how many hops to take that way. If the header is addressed to this switch's own coordinate, it goes out of the local port unchanged. Otherwise the stage uses up one hop of the first segment and sends the header to the matching neighbour port. That port is chosen from the carried route alone; the stage never compares coordinates to pick it.

The decision is made in one registered stage. A header held in that stage stays there, unchanged, until the chosen output accepts it. While it waits, the input is stalled, so headers leave in the order they arrived. With the output accepting, the stage takes one header per cycle. With each forwarded header the stage also gives the coordinate of the neighbour it goes to. That coordinate is the local one moved by one step, wrapping at the torus edge. A header that is not local but has no moves left cannot be routed. It is discarded, and a one-cycle error pulse is raised.

Top module: `torus_fwd_stage`

## Requirements
- R1: After reset no output valid is high, `drop_err` is low and `in_ready` is high.
- R2: A header whose destination equals (LOC_X, LOC_Y) leaves on `out_valid[0]` with destination, segment count, route and payload unchanged and with a hop coordinate equal to the local coordinate. This holds even when its segment count is zero.
- R3: A non-local header leaves on the port chosen by the direction field of segment 0. Direction codes are 0 = +X, 1 = −X, 2 = +Y and 3 = −Y, and they go to `out_valid` bits 1, 2, 3 and 4 respectively.
- R4: A route holds NSEG segments of DIR_W+CNTW bits each. Segment i sits at bits [i*SEGW +: SEGW], with the direction in its top two bits and the count in its low CNTW bits. Forwarding removes one move. If segment 0 has a count greater than 1, that count drops by one and nothing else changes. Otherwise segment 0 is removed, every later segment moves down one slot, the top slot is filled with zeros and the segment count drops by one.
- R5: The hop coordinate of a forwarded header is the local coordinate with the selected dimension changed by +1 or −1 modulo K. The other dimension is left unchanged.
- R6: A non-local header with a segment count of zero is accepted and discarded. No output valid rises for it, and `drop_err` is high for exactly the cycle after acceptance.
- R7: An accepted header appears at the outputs in the cycle right after the edge at which it was accepted.
- R8: While the held header's output is not ready, all output fields and `out_valid` stay stable, `in_ready` is low, and headers leave in the order they were accepted.
- R9: At most one bit of `out_valid` is high at any time.
- R10: With the selected outputs ready, a new header is accepted on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input header present |
| in_ready | output | 1 | Stage can accept a header this cycle |
| in_dst_x | input | CW | Destination X coordinate |
| in_dst_y | input | CW | Destination Y coordinate |
| in_nseg | input | NSW | Number of route segments in use |
| in_route | input | NSEG*SEGW | Run-length route, segment 0 in the low bits |
| in_payload | input | PW | Payload carried along |
| out_valid | output | 5 | One-hot valid: bit 0 local, 1 +X, 2 −X, 3 +Y, 4 −Y |
| out_ready | input | 5 | Per-port ready, same bit order |
| out_dst_x | output | CW | Destination X of the held header |
| out_dst_y | output | CW | Destination Y of the held header |
| out_nseg | output | NSW | Remaining segment count |
| out_route | output | NSEG*SEGW | Remaining route |
| out_payload | output | PW | Payload |
| out_hop_x | output | CW | X coordinate of the node the header goes to |
| out_hop_y | output | CW | Y coordinate of the node the header goes to |
| drop_err | output | 1 | One-cycle pulse for a discarded unroutable header |

## Verification
Some properties are checked on every cycle. These are: `out_valid` is one-hot or zero; a stalled header stays stable and blocks the input; a local delivery carries the local destination; the +X and −Y hop coordinates wrap; a drop pulse follows an unroutable acceptance; and a local header shows up one cycle after it is accepted. Other behaviour can only be shown by the bench's scenarios, because it needs a model of the route contents. That covers the exact route after a pop, including shifting the segments and freeing the top slot. It also covers keeping order across a stall, accepting back to back at full rate, and the exact cycle in which a drop pulse rises and falls.

// File: rtl/tfwd_pkg.sv
package tfwd_pkg;

    localparam int DIR_W  = 2;
    localparam int NPORTS = 5;

    typedef enum logic [DIR_W-1:0] {
        DIR_XP = 2'd0,
        DIR_XN = 2'd1,
        DIR_YP = 2'd2,
        DIR_YN = 2'd3
    } dir_e;

    localparam logic [2:0] PORT_LOCAL = 3'd0;

endpackage

// File: rtl/tfwd_route_pop.sv
module tfwd_route_pop
    import tfwd_pkg::*;
#(
    parameter int NSEG = 4,
    parameter int CNTW = 4,
    localparam int SEGW = DIR_W + CNTW,
    localparam int RW   = NSEG * SEGW,
    localparam int NSW  = $clog2(NSEG + 1)
) (
    input  logic [NSW-1:0] nseg_i,
    input  logic [RW-1:0]  route_i,
    output dir_e           dir_o,
    output logic           empty_o,
    output logic [NSW-1:0] nseg_o,
    output logic [RW-1:0]  route_o
);

    logic [SEGW-1:0] head;
    logic [CNTW-1:0] head_cnt;

    assign head     = route_i[SEGW-1:0];
    assign head_cnt = head[CNTW-1:0];
    assign dir_o    = dir_e'(head[SEGW-1 -: DIR_W]);
    assign empty_o  = (nseg_i == '0);

    always_comb begin
        route_o = route_i;
        nseg_o  = nseg_i;
        if (head_cnt > CNTW'(1)) begin
            // Decrement the run length of the first segment in place
            route_o[SEGW-1:0] = {head[SEGW-1 -: DIR_W], CNTW'(head_cnt - 1'b1)};
        end else begin
            // Last hop of this segment: shift the list down one slot
            for (int i = 0; i < NSEG; i++) begin
                if (i < NSEG - 1) begin
                    route_o[i*SEGW +: SEGW] = route_i[(i+1)*SEGW +: SEGW];
                end else begin
                    route_o[i*SEGW +: SEGW] = '0;
                end
            end
            nseg_o = NSW'(nseg_i - 1'b1);
        end
    end

endmodule

// File: rtl/tfwd_hop.sv
module tfwd_hop
    import tfwd_pkg::*;
#(
    parameter int K     = 4,
    parameter int LOC_X = 0,
    parameter int LOC_Y = 0,
    localparam int CW   = $clog2(K)
) (
    input  dir_e          dir_i,
    output logic [CW-1:0] hop_x_o,
    output logic [CW-1:0] hop_y_o
);

    logic [CW-1:0] inc_c [2];
    logic [CW-1:0] dec_c [2];

    for (genvar g = 0; g < 2; g++) begin : g_dim
        localparam int LC  = (g == 0) ? LOC_X : LOC_Y;
        localparam int INC = (LC == K - 1) ? 0 : LC + 1;
        localparam int DEC = (LC == 0) ? K - 1 : LC - 1;
        assign inc_c[g] = CW'(INC);
        assign dec_c[g] = CW'(DEC);
    end

    always_comb begin
        hop_x_o = CW'(LOC_X);
        hop_y_o = CW'(LOC_Y);
        unique case (dir_i)
            DIR_XP: hop_x_o = inc_c[0];
            DIR_XN: hop_x_o = dec_c[0];
            DIR_YP: hop_y_o = inc_c[1];
            DIR_YN: hop_y_o = dec_c[1];
            default: ;
        endcase
    end

endmodule

// File: rtl/torus_fwd_stage.sv
module torus_fwd_stage
    import tfwd_pkg::*;
#(
    parameter int K     = 4,
    parameter int LOC_X = 3,
    parameter int LOC_Y = 0,
    parameter int NSEG  = 4,
    parameter int CNTW  = 4,
    parameter int PW    = 16,
    localparam int CW   = $clog2(K),
    localparam int SEGW = DIR_W + CNTW,
    localparam int RW   = NSEG * SEGW,
    localparam int NSW  = $clog2(NSEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CW-1:0]     in_dst_x,
    input  logic [CW-1:0]     in_dst_y,
    input  logic [NSW-1:0]    in_nseg,
    input  logic [RW-1:0]     in_route,
    input  logic [PW-1:0]     in_payload,
    output logic [NPORTS-1:0] out_valid,
    input  logic [NPORTS-1:0] out_ready,
    output logic [CW-1:0]     out_dst_x,
    output logic [CW-1:0]     out_dst_y,
    output logic [NSW-1:0]    out_nseg,
    output logic [RW-1:0]     out_route,
    output logic [PW-1:0]     out_payload,
    output logic [CW-1:0]     out_hop_x,
    output logic [CW-1:0]     out_hop_y,
    output logic              drop_err
);

    typedef struct packed {
        logic           full;
        logic [2:0]     port;
        logic [CW-1:0]  dx;
        logic [CW-1:0]  dy;
        logic [CW-1:0]  hx;
        logic [CW-1:0]  hy;
        logic [NSW-1:0] nseg;
        logic [RW-1:0]  route;
        logic [PW-1:0]  pay;
        logic           err;
    } stage_t;

    stage_t st_d, st_q;

    dir_e           pop_dir;
    logic           pop_empty;
    logic [NSW-1:0] pop_nseg;
    logic [RW-1:0]  pop_route;
    logic [CW-1:0]  nb_x, nb_y;
    logic           is_local;
    logic           drain;
    logic           accept;

    tfwd_route_pop #(.NSEG(NSEG), .CNTW(CNTW)) u_pop (
        .nseg_i  (in_nseg),
        .route_i (in_route),
        .dir_o   (pop_dir),
        .empty_o (pop_empty),
        .nseg_o  (pop_nseg),
        .route_o (pop_route)
    );

    tfwd_hop #(.K(K), .LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_hop (
        .dir_i   (pop_dir),
        .hop_x_o (nb_x),
        .hop_y_o (nb_y)
    );

    assign is_local = (in_dst_x == CW'(LOC_X)) && (in_dst_y == CW'(LOC_Y));
    assign drain    = st_q.full && out_ready[st_q.port];
    assign in_ready = !st_q.full || drain;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (drain) begin
            st_d.full = 1'b0;
        end
        if (accept) begin
            if (is_local) begin
                st_d.full  = 1'b1;
                st_d.port  = PORT_LOCAL;
                st_d.dx    = in_dst_x;
                st_d.dy    = in_dst_y;
                st_d.hx    = CW'(LOC_X);
                st_d.hy    = CW'(LOC_Y);
                st_d.nseg  = in_nseg;
                st_d.route = in_route;
                st_d.pay   = in_payload;
            end else if (pop_empty) begin
                st_d.err = 1'b1;
            end else begin
                st_d.full  = 1'b1;
                st_d.port  = 3'(pop_dir) + 3'd1;
                st_d.dx    = in_dst_x;
                st_d.dy    = in_dst_y;
                st_d.hx    = nb_x;
                st_d.hy    = nb_y;
                st_d.nseg  = pop_nseg;
                st_d.route = pop_route;
                st_d.pay   = in_payload;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        out_valid = '0;
        if (st_q.full) begin
            out_valid[st_q.port] = 1'b1;
        end
    end

    assign out_dst_x   = st_q.dx;
    assign out_dst_y   = st_q.dy;
    assign out_nseg    = st_q.nseg;
    assign out_route   = st_q.route;
    assign out_payload = st_q.pay;
    assign out_hop_x   = st_q.hx;
    assign out_hop_y   = st_q.hy;
    assign drop_err    = st_q.err;

    // ---------------- assertions ----------------
    assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & ~out_ready) != '0) |=>
            ($stable(out_valid) && $stable(out_payload) && $stable(out_route)
             && $stable(out_nseg) && $stable(out_hop_x) && $stable(out_hop_y)));

    assert_stall_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & ~out_ready) != '0) |-> !in_ready);

    assert_local_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> (out_dst_x == CW'(LOC_X) && out_dst_y == CW'(LOC_Y)
                          && out_hop_x == CW'(LOC_X) && out_hop_y == CW'(LOC_Y)));

    assert_wrap_xp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] |-> (out_hop_x == CW'((LOC_X + 1) % K) && out_hop_y == CW'(LOC_Y)));

    assert_wrap_yn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[4] |-> (out_hop_y == CW'((LOC_Y + K - 1) % K) && out_hop_x == CW'(LOC_X)));

    assert_drop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |-> $past(in_valid && in_ready && in_nseg == '0));

    assert_local_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && is_local) |=> out_valid[0]);

endmodule

// File: tb/torus_fwd_stage_tb.sv
module torus_fwd_stage_tb_top;

    localparam int BK = 4;
    localparam int BX = 3;
    localparam int BY = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_dst_x = '0, in_dst_y = '0;
    logic [2:0]  in_nseg = '0;
    logic [23:0] in_route = '0;
    logic [15:0] in_payload = '0;
    logic [4:0]  out_valid;
    logic [4:0]  out_ready = '1;
    logic [1:0]  out_dst_x, out_dst_y, out_hop_x, out_hop_y;
    logic [2:0]  out_nseg;
    logic [23:0] out_route;
    logic [15:0] out_payload;
    logic        drop_err;

    always #2 clk = ~clk;   // 250 MHz

    torus_fwd_stage #(.K(BK), .LOC_X(BX), .LOC_Y(BY), .NSEG(4), .CNTW(4), .PW(16)) dut_i (
        .clk, .rst_n, .in_valid, .in_ready, .in_dst_x, .in_dst_y, .in_nseg,
        .in_route, .in_payload, .out_valid, .out_ready, .out_dst_x, .out_dst_y,
        .out_nseg, .out_route, .out_payload, .out_hop_x, .out_hop_y, .drop_err
    );

    typedef struct {
        int          port;
        logic [63:0] fields;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int acc_cyc = 0;

    always @(negedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] seg(input int d, input int c);
        return {2'(d), 4'(c)};
    endfunction

    // Spec model: returns 1 if the header is expected to be dropped
    function automatic bit model(input logic [1:0] dx, input logic [1:0] dy, input logic [2:0] ns,
                                 input logic [23:0] rt, input logic [15:0] pay, input string tag,
                                 output exp_t e);
        logic [1:0] hx, hy, d;
        logic [3:0] c;
        logic [23:0] r2;
        logic [2:0] n2;
        e.tag = tag;
        if (dx == 2'(BX) && dy == 2'(BY)) begin
            e.port = 0;
            e.fields = {13'd0, ns, rt, pay, dx, dy, 2'(BX), 2'(BY)};
            return 1'b0;
        end
        if (ns == 0) return 1'b1;
        d = rt[5:4];
        c = rt[3:0];
        hx = 2'(BX);
        hy = 2'(BY);
        case (d)
            2'd0: hx = 2'((BX + 1) % BK);
            2'd1: hx = 2'((BX + BK - 1) % BK);
            2'd2: hy = 2'((BY + 1) % BK);
            default: hy = 2'((BY + BK - 1) % BK);
        endcase
        if (c > 1) begin
            r2 = {rt[23:6], d, 4'(c - 1)};
            n2 = ns;
        end else begin
            r2 = rt >> 6;
            n2 = ns - 3'd1;
        end
        e.port = int'(d) + 1;
        e.fields = {13'd0, n2, r2, pay, dx, dy, hx, hy};
        return 1'b0;
    endfunction

    int exp_drops = 0;

    task automatic send(input logic [1:0] dx, input logic [1:0] dy, input logic [2:0] ns,
                        input logic [23:0] rt, input logic [15:0] pay, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_dst_x = dx; in_dst_y = dy; in_nseg = ns; in_route = rt; in_payload = pay;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        if (model(dx, dy, ns, rt, pay, tag, e)) exp_drops++;
        else q.push_back(e);
        @(posedge clk);
        acc_cyc = cyc;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (!$onehot0(out_valid))
                    chk(1'b0, "R9 onehot", 64'(out_valid), 64'd0);
                if ((out_valid & out_ready) != 0) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R6 unexpected output", 64'(out_valid), 64'd0);
                    end else begin
                        exp_t e;
                        logic [63:0] act;
                        e = q.pop_front();
                        act = {13'd0, out_nseg, out_route, out_payload,
                               out_dst_x, out_dst_y, out_hop_x, out_hop_y};
                        chk(out_valid == 5'(1 << e.port), {e.tag, " port"},
                            64'(out_valid), 64'(1 << e.port));
                        chk(act == e.fields, {e.tag, " fields"}, act, e.fields);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int first;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 0 && drop_err == 0 && in_ready == 1, "R1 reset state",
            {out_valid, drop_err, in_ready}, 64'b0000001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(out_valid == 0 && drop_err == 0 && in_ready == 1, "R1 after release",
            {out_valid, drop_err, in_ready}, 64'b0000001);

        // R2 + R7: local delivery, route left untouched
        send(2'(BX), 2'(BY), 3'd2, {12'd0, seg(2, 3), seg(0, 1)}, 16'hA001, "R2 local");
        idle();
        #1;
        chk(out_valid == 5'b00001, "R7 latency local", 64'(out_valid), 64'b00001);
        // R2 with empty route is still delivered
        send(2'(BX), 2'(BY), 3'd0, 24'd0, 16'hA002, "R2 local empty");
        idle();

        // R3/R5: +X wraps 3 -> 0, single move ends segment (R4)
        send(2'd1, 2'd0, 3'd1, {18'd0, seg(0, 1)}, 16'hB001, "R3 R5 +X wrap");
        // -X with count 3 -> 2 (R4)
        send(2'd1, 2'd1, 3'd1, {18'd0, seg(1, 3)}, 16'hB002, "R4 -X decrement");
        // +Y
        send(2'd0, 2'd2, 3'd2, {12'd0, seg(0, 2), seg(2, 2)}, 16'hB003, "R3 +Y");
        // -Y wraps 0 -> 3
        send(2'd3, 2'd2, 3'd1, {18'd0, seg(3, 2)}, 16'hB004, "R5 -Y wrap");
        // R4 multi-segment shift
        send(2'd2, 2'd1, 3'd3, {6'd0, seg(0, 1), seg(1, 2), seg(2, 1)}, 16'hB005, "R4 shift");
        idle();
        repeat (2) @(negedge clk);

        // R6 drop
        send(2'd1, 2'd2, 3'd0, {18'd0, seg(0, 1)}, 16'hC001, "R6 drop");
        idle();
        #1;
        chk(drop_err == 1'b1, "R6 drop pulse", 64'(drop_err), 64'd1);
        chk(out_valid == 0, "R6 no output", 64'(out_valid), 64'd0);
        @(negedge clk);
        #1;
        chk(drop_err == 1'b0, "R6 pulse ends", 64'(drop_err), 64'd0);

        // R8 back-pressure and ordering
        out_ready = 5'b00000;
        send(2'd1, 2'd0, 3'd1, {18'd0, seg(0, 1)}, 16'hD001, "R8 held first");
        idle();
        #1;
        held = out_payload;
        chk(out_valid == 5'b00010, "R8 held valid", 64'(out_valid), 64'b00010);
        fork
            send(2'd2, 2'd0, 3'd1, {18'd0, seg(2, 1)}, 16'hD002, "R8 queued second");
            begin
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    #1;
                    chk(out_valid == 5'b00010 && out_payload == held && !in_ready,
                        "R8 stall stable", {out_valid, out_payload, in_ready},
                        {5'b00010, held, 1'b0});
                end
                @(negedge clk);
                out_ready = 5'b11111;
            end
        join
        idle();
        repeat (2) @(negedge clk);

        // R10 back-to-back throughput
        send(2'(BX), 2'(BY), 3'd0, 24'd0, 16'hE001, "R10 stream 0");
        first = acc_cyc;
        send(2'd0, 2'd0, 3'd1, {18'd0, seg(0, 1)}, 16'hE002, "R10 stream 1");
        send(2'd3, 2'd3, 3'd1, {18'd0, seg(3, 1)}, 16'hE003, "R10 stream 2");
        send(2'd2, 2'd0, 3'd1, {18'd0, seg(1, 1)}, 16'hE004, "R10 stream 3");
        chk(acc_cyc - first == 3, "R10 one per cycle", 64'(acc_cyc - first), 64'd3);
        idle();

        repeat (6) @(negedge clk);
        #1;
        chk(q.size() == 0, "R8 all delivered in order", 64'(q.size()), 64'd0);
        chk(exp_drops == 1, "R6 drop count", 64'(exp_drops), 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule